// File: doc/BRIEF.md
# Raster Beam Position Counter

This block tracks where the display beam is on the screen. It keeps a 9-bit horizontal count and a 9-bit vertical count. Neither count runs straight through its range. The horizontal count runs through the visible pixels and part of horizontal blanking. It then jumps back to a high reload value and climbs through the top of the 9-bit range to reach zero, which starts the next line. The vertical count advances once per line, partway through horizontal blanking. During vertical blanking it also jumps to a high reload value before it wraps to zero.

Two mode inputs set the geometry. One picks a narrow (32-cell) or wide (40-cell) line. The other picks a short (28-cell) or tall (30-cell) frame. The block samples both inputs only when a new line starts. It also drives the two blanking flags and a 16-bit readback word. In interlace mode, that word moves the top vertical bit into the lowest bit of its upper byte.

An active-low asynchronous reset clears the block, and its release passes through two synchronizing flops. Counting advances only on clocks where the pixel enable is high.

Top module: `raster_pos_counter`

## Requirements
- R1: While reset is held, and for the first two clocks after its release, hpos, vpos, hblank, vblank and hv_word are all zero. The first line always runs with narrow and short geometry.
- R2: On a clock where pix_en is low, hpos, vpos and the active geometry keep their values.
- R3: With narrow geometry, hpos steps by one per enabled clock up to 0x128. The next step goes to 0x1D0, and the count then climbs through 0x1FF and wraps to 0x000.
- R4: With wide geometry, hpos steps by one up to 0x168, then goes to 0x1D0, and wraps through 0x1FF to 0x000 as in R3.
- R5: vpos advances on exactly those enabled clocks that bring hpos to 0x108 (narrow) or 0x148 (wide). It changes at no other time.
- R6: With short geometry, vpos counts 0x000 up to 0x0EA. Its next step is 0x1E5, and it then counts up to 0x1FF and wraps to 0x000, giving 262 lines.
- R7: With tall geometry, vpos counts 0x000 up to 0x10A. Its next step is 0x1D2, and it then counts up to 0x1FF and wraps to 0x000, giving 313 lines.
- R8: hblank is high exactly when hpos is above 0x0FE (narrow) or above 0x13E (wide).
- R9: vblank is high exactly when vpos is above 0x0DF (short) or above 0x0EF (tall).
- R10: wide_h and tall_v are sampled only on the enabled clock where hpos wraps from 0x1FF to 0x000. A change in the middle of a line leaves the rest of that line unaffected.
- R11: With interlace low, hv_word[15:8] = vpos[7:0] and hv_word[7:0] = hpos[8:1].
- R12: With interlace high, hv_word[15:9] = vpos[7:1], hv_word[8] = vpos[8] and hv_word[7:0] = hpos[8:1]. The interlace input acts on the word at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel enable; each high clock advances the counters |
| wide_h | input | 1 | Requested line geometry: 1 = 40-cell, 0 = 32-cell |
| tall_v | input | 1 | Requested frame geometry: 1 = 30-cell, 0 = 28-cell |
| interlace | input | 1 | Selects the interlace packing of hv_word |
| hpos | output | 9 | Horizontal count |
| vpos | output | 9 | Vertical count |
| hblank | output | 1 | Horizontal count outside the visible range |
| vblank | output | 1 | Vertical count outside the visible range |
| hv_word | output | 16 | Packed readback of both counts |

## Verification
The bench builds two instances with the default parameters, so every jump point and reload value is the real one. That is affordable because a full short frame of narrow lines takes about 90k clocks and a full tall frame about 108k. The first instance starts in short geometry. It first runs directed steps through its opening lines: blanking edges, the vertical step points, the pixel-enable hold, a deferred switch to a wide line, and both packings of the readback word. It then runs on past its vertical jump and wrap. The second instance runs a full tall frame in parallel, so both vertical jumps are reached within the cycle budget.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int unsigned POS_W = 9;

  // Horizontal geometry: last visible count, vertical step point, jump point
  localparam logic [POS_W-1:0] H_VIS_END_N = 9'h0FE;
  localparam logic [POS_W-1:0] H_VIS_END_W = 9'h13E;
  localparam logic [POS_W-1:0] H_VSTEP_N   = 9'h108;
  localparam logic [POS_W-1:0] H_VSTEP_W   = 9'h148;
  localparam logic [POS_W-1:0] H_JUMP_N    = 9'h128;
  localparam logic [POS_W-1:0] H_JUMP_W    = 9'h168;
  localparam logic [POS_W-1:0] H_RELOAD    = 9'h1D0;

  // Vertical geometry: last visible line, jump point, reload value
  localparam logic [POS_W-1:0] V_VIS_END_S = 9'h0DF;
  localparam logic [POS_W-1:0] V_VIS_END_T = 9'h0EF;
  localparam logic [POS_W-1:0] V_JUMP_S    = 9'h0EA;
  localparam logic [POS_W-1:0] V_JUMP_T    = 9'h10A;
  localparam logic [POS_W-1:0] V_RELOAD_S  = 9'h1E5;
  localparam logic [POS_W-1:0] V_RELOAD_T  = 9'h1D2;

  typedef struct packed {
    logic wide;
    logic tall;
  } scan_mode_t;

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount
  import raster_pkg::*;
#(
  parameter int unsigned      CNT_W     = POS_W,
  parameter logic [CNT_W-1:0] VIS_END_N = H_VIS_END_N,
  parameter logic [CNT_W-1:0] VIS_END_W = H_VIS_END_W,
  parameter logic [CNT_W-1:0] VSTEP_N   = H_VSTEP_N,
  parameter logic [CNT_W-1:0] VSTEP_W   = H_VSTEP_W,
  parameter logic [CNT_W-1:0] JUMP_N    = H_JUMP_N,
  parameter logic [CNT_W-1:0] JUMP_W    = H_JUMP_W,
  parameter logic [CNT_W-1:0] RELOAD    = H_RELOAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  scan_mode_t       mode_req,
  output scan_mode_t       mode_cur,
  output logic [CNT_W-1:0] hpos,
  output logic             hblank,
  output logic             v_step
);

  localparam logic [CNT_W-1:0] LINE_TOP = '1;

  logic [CNT_W-1:0] h_q, h_d;
  logic [CNT_W-1:0] jump_pt, vstep_pt, vis_end;
  scan_mode_t       mode_q, mode_d;
  logic             line_wrap;

  // next-state logic
  always_comb begin
    jump_pt   = mode_q.wide ? JUMP_W    : JUMP_N;
    vstep_pt  = mode_q.wide ? VSTEP_W   : VSTEP_N;
    vis_end   = mode_q.wide ? VIS_END_W : VIS_END_N;
    line_wrap = pix_en && (h_q == LINE_TOP);
    h_d       = h_q;
    if (pix_en) begin
      h_d = (h_q == jump_pt) ? RELOAD : h_q + 1'b1;
    end
    mode_d = line_wrap ? mode_req : mode_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      mode_q <= '0;
    end else begin
      if (pix_en) h_q <= h_d;
      if (line_wrap) mode_q <= mode_d;
    end
  end

  assign hpos     = h_q;
  assign mode_cur = mode_q;
  assign hblank   = (h_q > vis_end);
  assign v_step   = pix_en && (h_d == vstep_pt);

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
  import raster_pkg::*;
#(
  parameter int unsigned      CNT_W     = POS_W,
  parameter logic [CNT_W-1:0] VIS_END_S = V_VIS_END_S,
  parameter logic [CNT_W-1:0] VIS_END_T = V_VIS_END_T,
  parameter logic [CNT_W-1:0] JUMP_S    = V_JUMP_S,
  parameter logic [CNT_W-1:0] JUMP_T    = V_JUMP_T,
  parameter logic [CNT_W-1:0] RELOAD_S  = V_RELOAD_S,
  parameter logic [CNT_W-1:0] RELOAD_T  = V_RELOAD_T
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             tall,
  output logic [CNT_W-1:0] vpos,
  output logic             vblank
);

  logic [CNT_W-1:0] v_q, v_d;
  logic [CNT_W-1:0] jump_pt, reload_val, vis_end;

  always_comb begin
    jump_pt    = tall ? JUMP_T    : JUMP_S;
    reload_val = tall ? RELOAD_T  : RELOAD_S;
    vis_end    = tall ? VIS_END_T : VIS_END_S;
    v_d        = v_q;
    if (step) begin
      v_d = (v_q == jump_pt) ? reload_val : v_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (step) begin
      v_q <= v_d;
    end
  end

  assign vpos   = v_q;
  assign vblank = (v_q > vis_end);

endmodule

// File: rtl/raster_readback.sv
module raster_readback #(
  parameter int unsigned CNT_W = 9
) (
  input  logic               interlace,
  input  logic [CNT_W-2:0]   h_vis,
  input  logic [CNT_W-1:0]   vpos,
  output logic [2*CNT_W-3:0] word
);

  logic [CNT_W-2:0] hi_plain, hi_laced;

  always_comb begin
    hi_plain = vpos[CNT_W-2:0];
    hi_laced = {vpos[CNT_W-2:1], vpos[CNT_W-1]};
    word     = {(interlace ? hi_laced : hi_plain), h_vis};
  end

endmodule

// File: rtl/raster_pos_counter.sv
module raster_pos_counter
  import raster_pkg::*;
#(
  parameter int unsigned      CNT_W       = POS_W,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] HV_END_N    = H_VIS_END_N,
  parameter logic [CNT_W-1:0] HV_END_W    = H_VIS_END_W,
  parameter logic [CNT_W-1:0] HSTEP_N     = H_VSTEP_N,
  parameter logic [CNT_W-1:0] HSTEP_W     = H_VSTEP_W,
  parameter logic [CNT_W-1:0] HJUMP_N     = H_JUMP_N,
  parameter logic [CNT_W-1:0] HJUMP_W     = H_JUMP_W,
  parameter logic [CNT_W-1:0] HRELOAD     = H_RELOAD,
  parameter logic [CNT_W-1:0] VV_END_S    = V_VIS_END_S,
  parameter logic [CNT_W-1:0] VV_END_T    = V_VIS_END_T,
  parameter logic [CNT_W-1:0] VJUMP_S     = V_JUMP_S,
  parameter logic [CNT_W-1:0] VJUMP_T     = V_JUMP_T,
  parameter logic [CNT_W-1:0] VRELOAD_S   = V_RELOAD_S,
  parameter logic [CNT_W-1:0] VRELOAD_T   = V_RELOAD_T
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_en,
  input  logic               wide_h,
  input  logic               tall_v,
  input  logic               interlace,
  output logic [CNT_W-1:0]   hpos,
  output logic [CNT_W-1:0]   vpos,
  output logic               hblank,
  output logic               vblank,
  output logic [2*CNT_W-3:0] hv_word
);

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;
  scan_mode_t             mode_req, mode_cur;
  logic                   v_step;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  assign mode_req = '{wide: wide_h, tall: tall_v};

  raster_hcount #(
    .CNT_W(CNT_W), .VIS_END_N(HV_END_N), .VIS_END_W(HV_END_W),
    .VSTEP_N(HSTEP_N), .VSTEP_W(HSTEP_W), .JUMP_N(HJUMP_N),
    .JUMP_W(HJUMP_W), .RELOAD(HRELOAD)
  ) u_h (
    .clk(clk), .rst_n(rst_int_n), .pix_en(pix_en), .mode_req(mode_req),
    .mode_cur(mode_cur), .hpos(hpos), .hblank(hblank), .v_step(v_step)
  );

  raster_vcount #(
    .CNT_W(CNT_W), .VIS_END_S(VV_END_S), .VIS_END_T(VV_END_T),
    .JUMP_S(VJUMP_S), .JUMP_T(VJUMP_T), .RELOAD_S(VRELOAD_S),
    .RELOAD_T(VRELOAD_T)
  ) u_v (
    .clk(clk), .rst_n(rst_int_n), .step(v_step), .tall(mode_cur.tall),
    .vpos(vpos), .vblank(vblank)
  );

  raster_readback #(.CNT_W(CNT_W)) u_rb (
    .interlace(interlace), .h_vis(hpos[CNT_W-1:1]), .vpos(vpos),
    .word(hv_word)
  );

endmodule

// File: rtl/raster_pos_chk.sv
module raster_pos_chk #(
  parameter int unsigned      CNT_W   = 9,
  parameter logic [CNT_W-1:0] HV_END_N = 9'h0FE,
  parameter logic [CNT_W-1:0] HV_END_W = 9'h13E,
  parameter logic [CNT_W-1:0] HSTEP_N  = 9'h108,
  parameter logic [CNT_W-1:0] HSTEP_W  = 9'h148,
  parameter logic [CNT_W-1:0] HJUMP_N  = 9'h128,
  parameter logic [CNT_W-1:0] HJUMP_W  = 9'h168,
  parameter logic [CNT_W-1:0] HRELOAD  = 9'h1D0,
  parameter logic [CNT_W-1:0] VV_END_S = 9'h0DF,
  parameter logic [CNT_W-1:0] VV_END_T = 9'h0EF,
  parameter logic [CNT_W-1:0] VJUMP_S  = 9'h0EA,
  parameter logic [CNT_W-1:0] VJUMP_T  = 9'h10A,
  parameter logic [CNT_W-1:0] VRELOAD_S = 9'h1E5,
  parameter logic [CNT_W-1:0] VRELOAD_T = 9'h1D2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             wide_cur,
  input logic             tall_cur,
  input logic [CNT_W-1:0] hpos,
  input logic [CNT_W-1:0] vpos,
  input logic             hblank,
  input logic             vblank
);

  localparam logic [CNT_W-1:0] HB_FIRST_N = HV_END_N + 1'b1;
  localparam logic [CNT_W-1:0] HB_FIRST_W = HV_END_W + 1'b1;
  localparam logic [CNT_W-1:0] VB_FIRST_S = VV_END_S + 1'b1;
  localparam logic [CNT_W-1:0] VB_FIRST_T = VV_END_T + 1'b1;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(hpos) && $stable(vpos));

  // R3
  narrow_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && !wide_cur && hpos == HJUMP_N |=> hpos == HRELOAD);

  // R4
  wide_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && wide_cur && hpos == HJUMP_W |=> hpos == HRELOAD);

  // R5
  vstep_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vpos) |-> (hpos == HSTEP_N || hpos == HSTEP_W));

  // R6
  short_vjump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vpos) && $past(vpos) == VJUMP_S && !tall_cur |-> vpos == VRELOAD_S);

  // R7
  tall_vjump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vpos) && $past(vpos) == VJUMP_T && tall_cur |-> vpos == VRELOAD_T);

  // R8
  hblank_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hblank) && $stable(wide_cur) |-> (hpos == HB_FIRST_N || hpos == HB_FIRST_W));

  // R9
  vblank_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) && $stable(tall_cur) |-> (vpos == VB_FIRST_S || vpos == VB_FIRST_T));

  // R9
  vblank_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) && $stable(tall_cur) |-> vpos == '0);

  // R10
  mode_at_line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({wide_cur, tall_cur}) |-> hpos == '0);

endmodule

bind raster_pos_counter raster_pos_chk #(
  .CNT_W(CNT_W), .HV_END_N(HV_END_N), .HV_END_W(HV_END_W),
  .HSTEP_N(HSTEP_N), .HSTEP_W(HSTEP_W), .HJUMP_N(HJUMP_N),
  .HJUMP_W(HJUMP_W), .HRELOAD(HRELOAD), .VV_END_S(VV_END_S),
  .VV_END_T(VV_END_T), .VJUMP_S(VJUMP_S), .VJUMP_T(VJUMP_T),
  .VRELOAD_S(VRELOAD_S), .VRELOAD_T(VRELOAD_T)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .pix_en(pix_en),
  .wide_cur(mode_cur.wide), .tall_cur(mode_cur.tall),
  .hpos(hpos), .vpos(vpos), .hblank(hblank), .vblank(vblank)
);

// File: tb/raster_pos_counter_test.sv
module raster_pos_counter_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       pe_a, wide_a, tall_a, il_a;
  logic [8:0] h_a, v_a, h_b, v_b;
  logic       hb_a, vb_a, hb_b, vb_b;
  logic [15:0] w_a, w_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  raster_pos_counter uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pe_a), .wide_h(wide_a), .tall_v(tall_a),
    .interlace(il_a), .hpos(h_a), .vpos(v_a), .hblank(hb_a), .vblank(vb_a),
    .hv_word(w_a)
  );

  raster_pos_counter uut_v30 (
    .clk(clk), .rst_n(rst_n), .pix_en(1'b1), .wide_h(1'b0), .tall_v(1'b1),
    .interlace(1'b0), .hpos(h_b), .vpos(v_b), .hblank(hb_b), .vblank(vb_b),
    .hv_word(w_b)
  );

  // Checkpoints: {instance, vertical step index, expected vpos, expected vblank}
  localparam logic [19:0] CKPT [0:15] = '{
    {1'b0, 9'h0DF, 9'h0DF, 1'b0}, {1'b0, 9'h0E0, 9'h0E0, 1'b1},
    {1'b0, 9'h0EA, 9'h0EA, 1'b1}, {1'b0, 9'h0EB, 9'h1E5, 1'b1},
    {1'b0, 9'h0EC, 9'h1E6, 1'b1}, {1'b0, 9'h105, 9'h1FF, 1'b1},
    {1'b0, 9'h106, 9'h000, 1'b0}, {1'b0, 9'h107, 9'h001, 1'b0},
    {1'b1, 9'h0EF, 9'h0EF, 1'b0}, {1'b1, 9'h0F0, 9'h0F0, 1'b1},
    {1'b1, 9'h0FF, 9'h0FF, 1'b1}, {1'b1, 9'h100, 9'h100, 1'b1},
    {1'b1, 9'h10A, 9'h10A, 1'b1}, {1'b1, 9'h10B, 9'h1D2, 1'b1},
    {1'b1, 9'h138, 9'h1FF, 1'b1}, {1'b1, 9'h139, 9'h000, 1'b0}
  };

  // Record vpos/vblank after every vertical step of each instance
  logic [9:0] hist_a [0:399];
  logic [9:0] hist_b [0:399];
  int steps_a = 0, steps_b = 0;
  logic [8:0] prev_a = '0, prev_b = '0;

  always @(negedge clk) begin
    if (v_a !== prev_a) begin
      steps_a = steps_a + 1;
      if (steps_a < 400) hist_a[steps_a] = {vb_a, v_a};
    end
    if (v_b !== prev_b) begin
      steps_b = steps_b + 1;
      if (steps_b < 400) hist_b[steps_b] = {vb_b, v_b};
    end
    prev_a = v_a;
    prev_b = v_b;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pe_a = 1'b1; wide_a = 1'b0; tall_a = 1'b0; il_a = 1'b0;
    step(3);
    // R1 reset state
    chk("R1 hpos", h_a, 0); chk("R1 vpos", v_a, 0);
    chk("R1 flags", {hb_a, vb_a}, 0); chk("R1 word", w_a, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 hpos after release", h_a, 0);

    // line 0, narrow (R1 reset geometry, R3, R5, R8)
    step(9'h0FE); chk("R8 last visible", {hb_a, h_a}, {1'b0, 9'h0FE});
    step(1);      chk("R8 first blank", {hb_a, h_a}, {1'b1, 9'h0FF});
    step(8);      chk("R5 before step", {v_a, h_a}, {9'h000, 9'h107});
    step(1);      chk("R5 narrow step", {v_a, h_a}, {9'h001, 9'h108});
    step(9'h20);  chk("R3 jump point", h_a, 9'h128);
    step(1);      chk("R3 reload", {hb_a, h_a}, {1'b1, 9'h1D0});
    step(9'h2F);  chk("R3 top", h_a, 9'h1FF);
    step(1);      chk("R3 wrap", {hb_a, v_a, h_a}, {1'b0, 9'h001, 9'h000});

    // R2 enable low holds everything
    pe_a = 1'b0;
    step(5);      chk("R2 hold", {v_a, h_a}, {9'h001, 9'h000});
    pe_a = 1'b1;

    // R10 wide request mid-line: line 1 stays narrow
    wide_a = 1'b1;
    step(9'h128); chk("R10 still narrow", h_a, 9'h128);
    step(1);      chk("R10 narrow jump kept", h_a, 9'h1D0);
    step(9'h30);  chk("R10 wrap", h_a, 9'h000);

    // line 2 wide (R4, R5, R8)
    step(9'h129); chk("R4 no narrow jump", h_a, 9'h129);
    step(9'h15);  chk("R8 wide visible", {hb_a, h_a}, {1'b0, 9'h13E});
    step(1);      chk("R8 wide blank", {hb_a, h_a}, {1'b1, 9'h13F});
    step(8);      chk("R5 wide before", {v_a, h_a}, {9'h002, 9'h147});
    step(1);      chk("R5 wide step", {v_a, h_a}, {9'h003, 9'h148});
    step(9'h20);  chk("R4 jump point", h_a, 9'h168);
    step(1);      chk("R4 reload", h_a, 9'h1D0);
    wide_a = 1'b0;

    // R11 / R12 readback packing
    chk("R11 plain word", w_a, 16'h03E8);
    il_a = 1'b1; #1;
    chk("R12 laced word", w_a, 16'h02E8);
    il_a = 1'b0;

    // R12 with vpos bit 8 set (vpos 0x1E6, hpos 0x108)
    wait (steps_a == 9'h0EC);
    chk("R11 plain high", w_a, 16'hE684);
    il_a = 1'b1; #1;
    chk("R12 laced high", w_a, 16'hE784);
    il_a = 1'b0;

    wait (steps_a >= 263 && steps_b >= 313);
    step(1);

    // checkpoint walk: R6 short frame, R7 tall frame, R9 vblank
    for (int i = 0; i < 16; i++) begin
      logic [9:0] got;
      got = CKPT[i][19] ? hist_b[CKPT[i][18:10]] : hist_a[CKPT[i][18:10]];
      chk(CKPT[i][19] ? "R7/R9 tall frame" : "R6/R9 short frame",
          got, {CKPT[i][0], CKPT[i][9:1]});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule